// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block fetches one 16-bit word from a three-wire serial configuration EEPROM. A single-cycle start request carries a 6-bit word address. The block then runs a fixed bit-banged transaction on the serial clock, chip select and data-in pins, and the device answers on its data-out line.

After one idle half period with chip select low, the block raises chip select. It shifts an 11-bit command word out MSB first: two zero bits, the start-plus-read code `110`, then the address. It drives one more low clock half period. It then takes 16 data bits, MSB first, sampling data-out at the end of each clock-high half. Chip select falls, `busy_o` drops and `done_o` pulses once, with the word on `data_o`.

Every half period lasts `HALF_CLKS` system clocks, so the serial rate can be fitted to the device. Firmware usually reads word 0 first. An all-ones answer there means no device is fitted, because an absent device leaves data-out pulled high. The station address sits in words 7 to 9.

Top module: `eeprom_word_reader`

## Requirements
- R1: While reset is high and after it, until the first start, `busy_o`, `done_o`, `cs_o`, `sk_o`, `di_o` are 0 and `data_o` is 0.
- R2: A start seen while idle raises `busy_o` in the next cycle. `cs_o` stays low for the first half period, then stays high until the end of the access.
- R3: The command is 11 bits sent MSB first: 0, 0, 1, 1, 0, then the address bits a5..a0. Each bit is placed on `di_o` during a half period with `sk_o` low and held through the following half period with `sk_o` high.
- R4: Every half period of the serial sequence lasts exactly `HALF_CLKS` system clocks (default 4).
- R5: After the command, `sk_o` stays low for one half period. Then 16 high/low clock pairs follow, with `di_o` at 0, giving 27 rising serial clock edges per access.
- R6: Each data bit is taken from `do_i` at the end of a clock-high half period, MSB first. The word appears on `data_o` in the cycle `done_o` is high and holds until the next completion.
- R7: After the last data half period, `cs_o` and `sk_o` go low, `busy_o` falls and `done_o` is high for exactly one cycle. An access takes 56 half periods.
- R8: A start while `busy_o` is high is ignored. The running access, its address and its result are unchanged.
- R9: A start present in the cycle `done_o` is high is accepted, so `busy_o` is high again in the next cycle.
- R10: With `do_i` held high (no device), or when the addressed word is all ones, the result is 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to read one word |
| addr_i | input | ADDR_W | Word address, captured at an accepted start |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle completion pulse |
| data_o | output | DATA_W | Last word read |
| sk_o | output | 1 | Serial clock to the EEPROM |
| cs_o | output | 1 | Chip select to the EEPROM |
| di_o | output | 1 | Serial data to the EEPROM |
| do_i | input | 1 | Serial data from the EEPROM |

## Verification
Completion of one access and acceptance of the next can land in the same cycle. The bench provokes this by holding the start request high across a completion. It then judges that `done_o` pulses while `busy_o` is low for that single cycle only, that the old word is presented, and that the new access begins its idle chip-select half period in the very next cycle. A start pulse injected mid-access with a different address checks that the busy guard keeps the latched address. A per-clock reference trace of pin levels compares every cycle of both accesses.

// File: rtl/eeprom_rd_pkg.sv
package eeprom_rd_pkg;

  // start bit plus read code, shifted above the word address
  localparam logic [2:0] RD_CODE = 3'b110;
  localparam int         LEAD_ZEROS = 2;

  typedef struct packed {
    logic cs;
    logic sk;
    logic di;
  } pins_t;

endpackage

// File: rtl/eeprom_rd_timer.sv
module eeprom_rd_timer #(
  parameter int HALF_CLKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_CLKS - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick = run && (cnt_q == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  // R4: the half-period counter never passes its terminal count
  p_cnt_range_r4: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_LAST);

  // R4: counter restarts from zero after every half-period boundary
  p_restart_r4: assert property (@(posedge clk) disable iff (rst)
    tick |=> (cnt_q == '0));

endmodule

// File: rtl/eeprom_rd_seq.sv
module eeprom_rd_seq #(
  parameter int STEPS = 56
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start_i,
  input  logic                       tick,
  output logic                       busy_q,
  output logic                       busy_d,
  output logic [$clog2(STEPS)-1:0]   step_q,
  output logic [$clog2(STEPS)-1:0]   step_d,
  output logic                       launch,
  output logic                       finish,
  output logic                       done_q
);
  localparam int STEP_W = $clog2(STEPS);
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(STEPS - 1);

  assign launch = start_i && !busy_q;
  assign finish = busy_q && tick && (step_q == STEP_LAST);
  assign busy_d = launch || (busy_q && !finish);

  always_comb begin
    step_d = step_q;
    if (launch)                          step_d = '0;
    else if (busy_q && tick && !finish)  step_d = step_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      step_q <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      step_q <= step_d;
      done_q <= finish;
    end
  end

  // R8: a request during an access neither restarts nor stops it
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start_i && !tick) |=> (busy_q && $stable(step_q)));

  // R7: completion pulse lasts a single cycle
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R7: completion coincides with the end of busy
  p_done_ends_busy_r7: assert property (@(posedge clk) disable iff (rst)
    done_q |-> $fell(busy_q));

endmodule

// File: rtl/eeprom_rd_pins.sv
module eeprom_rd_pins
  import eeprom_rd_pkg::*;
#(
  parameter int CMD_W  = 11,
  parameter int STEP_W = 6
) (
  input  logic [STEP_W-1:0] step,
  input  logic              active,
  input  logic [CMD_W-1:0]  cmd,
  output pins_t             pins
);
  localparam int CMD_END = 2 * CMD_W;   // last command step
  localparam int GAP     = CMD_END + 1; // low-clock step before data

  always_comb begin
    int s;
    int k;
    s = int'(step);
    k = 0;
    pins = '0;
    if (active && s != 0) begin
      pins.cs = 1'b1;
      if (s <= CMD_END) begin
        k       = s - 1;
        pins.sk = k[0];
        pins.di = cmd[CMD_W - 1 - (k / 2)];
      end else if (s > GAP) begin
        k       = s - GAP - 1;
        pins.sk = !k[0];
      end
    end
  end

endmodule

// File: rtl/eeprom_word_reader.sv
module eeprom_word_reader
  import eeprom_rd_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 16,
  parameter int HALF_CLKS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              sk_o,
  output logic              cs_o,
  output logic              di_o,
  input  logic              do_i
);
  localparam int CMD_W      = LEAD_ZEROS + 3 + ADDR_W;
  localparam int STEPS      = 2 + 2 * CMD_W + 2 * DATA_W;
  localparam int STEP_W     = $clog2(STEPS);
  localparam int DATA_FIRST = 2 * CMD_W + 2;

  logic              tick, launch, finish, busy_q, busy_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [CMD_W-1:0]  cmd_q, cmd_d;
  logic [DATA_W-1:0] shift_q;
  pins_t             pins_d;
  logic              sample_en;

  eeprom_rd_timer #(.HALF_CLKS(HALF_CLKS)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .run  (busy_q),
    .tick (tick)
  );

  eeprom_rd_seq #(.STEPS(STEPS)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .tick    (tick),
    .busy_q  (busy_q),
    .busy_d  (busy_d),
    .step_q  (step_q),
    .step_d  (step_d),
    .launch  (launch),
    .finish  (finish),
    .done_q  (done_o)
  );

  assign cmd_d = launch ? {{LEAD_ZEROS{1'b0}}, RD_CODE, addr_i} : cmd_q;

  eeprom_rd_pins #(.CMD_W(CMD_W), .STEP_W(STEP_W)) u_pins (
    .step   (step_d),
    .active (busy_d),
    .cmd    (cmd_d),
    .pins   (pins_d)
  );

  // data bit is taken at the close of each clock-high half period
  always_comb begin
    int s;
    s = int'(step_q);
    sample_en = (s >= DATA_FIRST) && !((s - DATA_FIRST) & 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q   <= '0;
      shift_q <= '0;
      data_o  <= '0;
      cs_o    <= 1'b0;
      sk_o    <= 1'b0;
      di_o    <= 1'b0;
    end else begin
      cmd_q <= cmd_d;
      cs_o  <= pins_d.cs;
      sk_o  <= pins_d.sk;
      di_o  <= pins_d.di;
      if (busy_q && tick && sample_en)
        shift_q <= {shift_q[DATA_W-2:0], do_i};
      if (finish)
        data_o <= shift_q;
    end
  end

  assign busy_o = busy_q;

  // R7: chip select never active outside an access
  p_cs_in_access_r7: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !cs_o);

  // R1: serial clock idles low whenever no access runs
  p_sk_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (!sk_o && !di_o));

  // R3: data-in is already settled when the serial clock rises
  p_di_hold_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(sk_o) |-> $stable(di_o));

  // R2: an accepted start opens with chip select low
  p_pre_cs_low_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> !cs_o);

  // R6: result register only moves at completion
  p_data_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(data_o));

endmodule

// File: tb/test_eeprom_word_reader.sv
module test_eeprom_word_reader;
  localparam int HALF = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [5:0]  addr_i = '0;
  logic        busy_o, done_o, sk_o, cs_o, di_o;
  logic [15:0] data_o;
  logic        eep_do = 1'b1;
  logic        present = 1'b1;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk; // 125 MHz

  eeprom_word_reader #(.ADDR_W(6), .DATA_W(16), .HALF_CLKS(HALF)) i_eeprom_word_reader (
    .clk (clk), .rst (rst), .start_i (start_i), .addr_i (addr_i),
    .busy_o (busy_o), .done_o (done_o), .data_o (data_o),
    .sk_o (sk_o), .cs_o (cs_o), .di_o (di_o), .do_i (eep_do)
  );

  function automatic logic [15:0] word_of(logic [5:0] a);
    if (a == 6'd0) return 16'hFFFF;
    return (16'(a) * 16'h2F1D) ^ 16'hC35A;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural EEPROM ----------------
  int         ccnt = 0, dcnt = 0, last_edges = 0;
  logic [10:0] creg = '0;
  logic        sk_prev = 1'b0, cs_prev = 1'b0;
  always @(posedge clk) begin
    if (!cs_o) begin
      if (cs_prev) last_edges = ccnt + dcnt;
      ccnt = 0; dcnt = 0; eep_do <= 1'b1;
    end else if (sk_o && !sk_prev) begin
      if (ccnt < 11) begin
        creg = {creg[9:0], di_o};
        ccnt++;
        if (ccnt == 11) check("R3 opcode", 16'(creg[10:6]), 16'h0006);
      end else begin
        logic [15:0] w;
        w = word_of(creg[5:0]);
        eep_do <= present ? w[15 - dcnt] : 1'b1;
        dcnt++;
      end
    end
    sk_prev = sk_o;
    cs_prev = cs_o;
  end

  // ---------------- cycle reference model ----------------
  logic [4:0]  exp_q[$];   // {done, busy, cs, sk, di}
  logic [15:0] exp_dq[$];
  logic [15:0] exp_data = '0;
  logic        model_busy = 1'b0;
  bit          chk_on = 1'b0;

  task automatic push_half(logic cs, logic sk, logic di);
    repeat (HALF) exp_q.push_back({1'b0, 1'b1, cs, sk, di});
  endtask

  task automatic push_read(logic [5:0] a);
    logic [10:0] f;
    f = {2'b00, 3'b110, a};
    push_half(1'b0, 1'b0, 1'b0);
    for (int i = 10; i >= 0; i--) begin
      push_half(1'b1, 1'b0, f[i]);
      push_half(1'b1, 1'b1, f[i]);
    end
    push_half(1'b1, 1'b0, 1'b0);
    for (int j = 0; j < 16; j++) begin
      push_half(1'b1, 1'b1, 1'b0);
      push_half(1'b1, 1'b0, 1'b0);
    end
    exp_q.push_back(5'b10000);
    exp_dq.push_back(present ? word_of(a) : 16'hFFFF);
  endtask

  always @(posedge clk) begin
    chk_on <= 1'b1;
    if (!rst && start_i && !model_busy) push_read(addr_i);
  end

  always @(negedge clk) begin
    if (chk_on) begin
      logic [4:0] e;
      e = (exp_q.size() != 0) ? exp_q.pop_front() : 5'b00000;
      if (e[4]) exp_data = exp_dq.pop_front();
      check("R7 done", 16'(done_o), 16'(e[4]));
      check("R8 busy", 16'(busy_o), 16'(e[3]));
      check("R2 cs",   16'(cs_o),   16'(e[2]));
      check("R4 sk",   16'(sk_o),   16'(e[1]));
      check("R3 di",   16'(di_o),   16'(e[0]));
      check("R6 data", data_o, exp_data);
      model_busy = e[3];
    end
  end

  // ---------------- stimulus ----------------
  task automatic wait_done();
    do @(negedge clk); while (!done_o);
  endtask

  task automatic read_word(logic [5:0] a);
    @(negedge clk); start_i = 1'b1; addr_i = a;
    @(negedge clk); start_i = 1'b0;
    wait_done();
    repeat (3) @(negedge clk);
    check("R5 edge count", 16'(last_edges), 16'd27);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check("R1 reset busy", 16'(busy_o), 16'd0);
    check("R1 reset data", data_o, 16'h0000);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 idle pins", 16'({cs_o, sk_o, di_o}), 16'd0);

    read_word(6'd7);  check("R6 word 7", data_o, word_of(6'd7));
    read_word(6'd8);  check("R6 word 8", data_o, word_of(6'd8));
    read_word(6'd9);  check("R6 word 9", data_o, word_of(6'd9));
    read_word(6'd63); check("R6 word 63", data_o, word_of(6'd63));
    read_word(6'd42); check("R6 word 42", data_o, word_of(6'd42));
    read_word(6'd0);  check("R10 word 0 all ones", data_o, 16'hFFFF);

    // R8: start mid-access with another address
    @(negedge clk); start_i = 1'b1; addr_i = 6'd5;
    @(negedge clk); start_i = 1'b0; addr_i = 6'd0;
    repeat (40) @(negedge clk);
    start_i = 1'b1; addr_i = 6'd9;
    @(negedge clk); start_i = 1'b0; addr_i = 6'd0;
    wait_done();
    check("R8 ignored start keeps result", data_o, word_of(6'd5));
    repeat (3) @(negedge clk);

    // R9: start held across completion
    @(negedge clk); start_i = 1'b1; addr_i = 6'd21;
    wait_done();
    check("R9 old word at done", data_o, word_of(6'd21));
    @(negedge clk);
    check("R9 relaunch busy", 16'(busy_o), 16'd1);
    check("R9 relaunch cs low", 16'(cs_o), 16'd0);
    wait_done();
    start_i = 1'b0;
    check("R9 second word", data_o, word_of(6'd21));
    repeat (3) @(negedge clk);
    check("R9 idle after", 16'(busy_o), 16'd0);

    // R10: no device fitted
    present = 1'b0;
    read_word(6'd3);
    check("R10 absent device", data_o, 16'hFFFF);
    present = 1'b1;

    repeat (5) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule